// File: doc/BRIEF.md
# Sweep Mode Control Register with Peak-Detect Gating

This block stores the eight-bit word that selects how the timebase sweeps behave, and decodes it into the control levels the rest of the sweep logic needs. A controller writes the whole word at once through a parallel load port. From the stored word the block derives two forced-zero flags for the delay comparators, an inhibit for the B sweep, and pass-through levels for the A-sweep free-run select, the B-sweep run select and the intensified-zone mode.

The block also produces the enable for the peak detector. Four selectable sources drive it:
- always on
- the external C gate
- the A gate
- a window held by a flip-flop, which opens on the end-of-delay strobe and closes on the end-of-A-sweep strobe

The window flip-flop follows both strobes in every mode. A switch into window mode therefore shows whatever state the strobes last left it in.

Top module: `sweep_ctrl`

## Requirements
- R1: While reset is active, and after it is released with no load, the stored word is all zeros and the window flip-flop is cleared. The outputs are then: first_delay_zero=1, second_delay_zero=0, b_sweep_inhibit=0, b_run=0, a_free_run=0, zone_mode=00, and peak_det_en=1.
- R2: On a rising clock edge with load high, the whole of load_data is stored and the outputs reflect it after that edge. With load low, the stored word and every output derived from it hold. The field positions are:
  - bit 0: delay mode low
  - bit 1: delay mode high
  - bit 2: B-run
  - bit 3: peak mode low
  - bit 4: peak mode high
  - bits 6:5: zone mode
  - bit 7: A free-run
- R3: Delay mode 00 sets first_delay_zero=1 and second_delay_zero=0, with b_sweep_inhibit=0.
- R4: Delay mode 01 sets both first_delay_zero and second_delay_zero to 1. The second flag is never high without the first.
- R5: Delay mode 10 sets both zero flags and b_sweep_inhibit to 0. Delay mode 11 sets b_sweep_inhibit=1 with both zero flags at 0.
- R6: Peak mode 00 holds peak_det_en at 1 regardless of the gates and strobes.
- R7: Peak mode 10 makes peak_det_en follow c_gate in the same cycle. Peak mode 11 makes it follow a_gate in the same cycle.
- R8: Peak mode 01 drives peak_det_en from the window flip-flop. The flip-flop works as follows:
  - It sets on an edge where dly_end is high and clears on an edge where a_sweep_end is high.
  - It holds when neither strobe is high.
  - It responds to the strobes in every peak mode.
  - The result is visible from the cycle after the edge.
- R9: When dly_end and a_sweep_end are both high on the same edge, the window flip-flop clears.
- R10: The zone-mode field is only stored and driven onto zone_mode. A change to it alters no other output.
- R11: The A free-run bit drives a_free_run and the B-run bit drives b_run unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Store load_data on the next rising edge |
| load_data | input | 8 | Control word to store |
| a_gate | input | 1 | A-sweep gate level |
| c_gate | input | 1 | External C gate level |
| dly_end | input | 1 | End-of-delay strobe |
| a_sweep_end | input | 1 | End-of-A-sweep strobe |
| first_delay_zero | output | 1 | Force first delay to zero |
| second_delay_zero | output | 1 | Force second delay to zero |
| b_sweep_inhibit | output | 1 | Prevent B sweep from running |
| b_run | output | 1 | Stored B-run select |
| a_free_run | output | 1 | Stored A free-run select (1 = free run) |
| zone_mode | output | 2 | Stored intensified-zone mode |
| peak_det_en | output | 1 | Peak-detector enable |

## Verification
Each delay-mode code is loaded in turn, which separates the four flag combinations and exposes swapped or mis-positioned field bits. The peak enable is driven in each mode with opposing levels on a_gate and c_gate, so a wrongly chosen source shows at once. Window mode is tried with the following strobe patterns:
- a lone set
- an idle hold
- a lone clear
- both strobes together, from an open window and from a closed one
- a set taken while another mode is selected

These patterns separate the priority, the hold behaviour and a flip-flop that only runs in window mode. Zone-only rewrites and loads with the load strobe low confirm that no other output moves.

// File: rtl/sweep_ctrl_pkg.sv
package sweep_ctrl_pkg;

   localparam int CTRL_W   = 8;
   localparam int DM_LSB   = 0;
   localparam int BRUN_BIT = 2;
   localparam int PM_LSB   = 3;
   localparam int ZM_LSB   = 5;
   localparam int ARUN_BIT = 7;

   typedef enum logic [1:0] {
      DLY_FIRST_ZERO = 2'b00,
      DLY_BOTH_ZERO  = 2'b01,
      DLY_NORMAL     = 2'b10,
      DLY_B_OFF      = 2'b11
   } dly_mode_e;

   typedef enum logic [1:0] {
      PK_ALWAYS = 2'b00,
      PK_WINDOW = 2'b01,
      PK_CGATE  = 2'b10,
      PK_AGATE  = 2'b11
   } peak_mode_e;

   typedef struct packed {
      logic       a_free_run;
      logic [1:0] zone;
      peak_mode_e peak;
      logic       b_run;
      dly_mode_e  dly;
   } ctrl_fields_t;

endpackage

// File: rtl/sweep_ctrl_reg.sv
module sweep_ctrl_reg #(
   parameter int              W         = 8,
   parameter logic [W-1:0]    RESET_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_data,
   output logic [W-1:0] ctrl_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ctrl_q <= RESET_VAL;
      else if (load) ctrl_q <= load_data;
   end

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(ctrl_q));

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (ctrl_q == $past(load_data)));

endmodule

// File: rtl/sweep_mode_decode.sv
module sweep_mode_decode
   import sweep_ctrl_pkg::*;
#(
   parameter int W = CTRL_W
) (
   input  logic [W-1:0] ctrl_word,
   output ctrl_fields_t fields,
   output logic         first_delay_zero,
   output logic         second_delay_zero,
   output logic         b_sweep_inhibit
);

   always_comb begin
      fields.dly        = dly_mode_e'(ctrl_word[DM_LSB +: 2]);
      fields.b_run      = ctrl_word[BRUN_BIT];
      fields.peak       = peak_mode_e'(ctrl_word[PM_LSB +: 2]);
      fields.zone       = ctrl_word[ZM_LSB +: 2];
      fields.a_free_run = ctrl_word[ARUN_BIT];
   end

   always_comb begin
      first_delay_zero  = 1'b0;
      second_delay_zero = 1'b0;
      b_sweep_inhibit   = 1'b0;
      unique case (fields.dly)
         DLY_FIRST_ZERO: first_delay_zero = 1'b1;
         DLY_BOTH_ZERO: begin
            first_delay_zero  = 1'b1;
            second_delay_zero = 1'b1;
         end
         DLY_NORMAL: ;
         DLY_B_OFF:  b_sweep_inhibit = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/sweep_peak_gate.sv
module sweep_peak_gate
   import sweep_ctrl_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  peak_mode_e mode,
   input  logic       a_gate,
   input  logic       c_gate,
   input  logic       dly_end,
   input  logic       a_sweep_end,
   output logic       peak_en
);

   logic window_q;
   logic peak_sel;

   // Window flip-flop: clear has priority over set.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           window_q <= 1'b0;
      else if (a_sweep_end) window_q <= 1'b0;
      else if (dly_end)     window_q <= 1'b1;
   end

   always_comb begin
      unique case (mode)
         PK_ALWAYS: peak_sel = 1'b1;
         PK_WINDOW: peak_sel = window_q;
         PK_CGATE:  peak_sel = c_gate;
         PK_AGATE:  peak_sel = a_gate;
         default:   peak_sel = 1'b1;
      endcase
   end

   generate
      if (REG_OUT) begin : g_reg_out
         logic peak_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) peak_q <= 1'b1;
            else        peak_q <= peak_sel;
         end
         assign peak_en = peak_q;
      end else begin : g_comb_out
         assign peak_en = peak_sel;

         assert_nongated_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == PK_ALWAYS) |-> peak_en);

         assert_gate_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ((mode == PK_CGATE) |-> (peak_en == c_gate)) and
            ((mode == PK_AGATE) |-> (peak_en == a_gate)));
      end
   endgenerate

   assert_window_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_end && !a_sweep_end) |=> window_q);

   assert_window_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!dly_end && !a_sweep_end) |=> $stable(window_q));

   assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      a_sweep_end |=> !window_q);

endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
   import sweep_ctrl_pkg::*;
#(
   parameter int                 W            = CTRL_W,
   parameter logic [CTRL_W-1:0]  RESET_VAL    = '0,
   parameter bit                 PEAK_REG_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_data,
   input  logic         a_gate,
   input  logic         c_gate,
   input  logic         dly_end,
   input  logic         a_sweep_end,
   output logic         first_delay_zero,
   output logic         second_delay_zero,
   output logic         b_sweep_inhibit,
   output logic         b_run,
   output logic         a_free_run,
   output logic [1:0]   zone_mode,
   output logic         peak_det_en
);

   generate
      if (W != CTRL_W) begin : g_bad_width
         $error("sweep_ctrl: W must equal the packed field layout width");
      end
   endgenerate

   logic [W-1:0] ctrl_q;
   ctrl_fields_t fields;

   sweep_ctrl_reg #(.W(W), .RESET_VAL(RESET_VAL)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_data (load_data),
      .ctrl_q    (ctrl_q)
   );

   sweep_mode_decode #(.W(W)) u_dec (
      .ctrl_word         (ctrl_q),
      .fields            (fields),
      .first_delay_zero  (first_delay_zero),
      .second_delay_zero (second_delay_zero),
      .b_sweep_inhibit   (b_sweep_inhibit)
   );

   sweep_peak_gate #(.REG_OUT(PEAK_REG_OUT)) u_peak (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (fields.peak),
      .a_gate      (a_gate),
      .c_gate      (c_gate),
      .dly_end     (dly_end),
      .a_sweep_end (a_sweep_end),
      .peak_en     (peak_det_en)
   );

   assign b_run      = fields.b_run;
   assign a_free_run = fields.a_free_run;
   assign zone_mode  = fields.zone;

   assert_second_needs_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      second_delay_zero |-> first_delay_zero);

   assert_inhibit_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      b_sweep_inhibit |-> (!first_delay_zero && !second_delay_zero));

   assert_zone_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (load_data[ZM_LSB +: 2] != zone_mode) &&
       ((load_data & ~(W'(3) << ZM_LSB)) == (ctrl_q & ~(W'(3) << ZM_LSB))))
      |=> ($stable(first_delay_zero) && $stable(second_delay_zero) &&
           $stable(b_sweep_inhibit) && $stable(b_run) && $stable(a_free_run)));

endmodule

// File: tb/tb_sweep_ctrl.sv
module tb_sweep_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load = 1'b0;
   logic [7:0] load_data = '0;
   logic       a_gate = 1'b0, c_gate = 1'b0, dly_end = 1'b0, a_sweep_end = 1'b0;
   logic       first_delay_zero, second_delay_zero, b_sweep_inhibit;
   logic       b_run, a_free_run, peak_det_en;
   logic [1:0] zone_mode;

   always #5 clk = ~clk;

   sweep_ctrl dut (
      .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data),
      .a_gate(a_gate), .c_gate(c_gate), .dly_end(dly_end), .a_sweep_end(a_sweep_end),
      .first_delay_zero(first_delay_zero), .second_delay_zero(second_delay_zero),
      .b_sweep_inhibit(b_sweep_inhibit), .b_run(b_run), .a_free_run(a_free_run),
      .zone_mode(zone_mode), .peak_det_en(peak_det_en)
   );

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } item_t;

   item_t      sb_q[$];
   item_t      cur;
   event       item_ev;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;
   logic [7:0] m_reg = '0;
   logic       m_win = 1'b0;

   // Bench-side encoding: {a_free_run, zone[1:0], peak[1:0], b_run, dly[1:0]}
   function automatic logic [7:0] mk(input logic [1:0] dm, input logic br,
                                     input logic [1:0] pm, input logic [1:0] zm,
                                     input logic ar);
      return {ar, zm, pm, br, dm};
   endfunction

   function automatic logic [7:0] expect_vec(input logic a, input logic c);
      logic       pk;
      logic [1:0] dm;
      dm = m_reg[1:0];
      case (m_reg[4:3])
         2'b00:   pk = 1'b1;
         2'b01:   pk = m_win;
         2'b10:   pk = c;
         default: pk = a;
      endcase
      return {m_reg[6:5], m_reg[7], m_reg[2],
              (dm == 2'b00) || (dm == 2'b01), dm == 2'b01, dm == 2'b11, pk};
   endfunction

   function automatic logic [7:0] out_vec();
      return {zone_mode, a_free_run, b_run, first_delay_zero,
              second_delay_zero, b_sweep_inhibit, peak_det_en};
   endfunction

   task automatic compare(input logic [7:0] exp, input string tag);
      checks++;
      if (out_vec() !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", tag, out_vec(), exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      load = 1'b0; load_data = '0;
      a_gate = 1'b0; c_gate = 1'b0; dly_end = 1'b0; a_sweep_end = 1'b0;
      m_reg = '0; m_win = 1'b0;
      repeat (2) @(negedge clk);
      #1 compare(expect_vec(1'b0, 1'b0), "R1");
      @(negedge clk) rst_n = 1'b1;
   endtask

   // Driver: apply one cycle of stimulus, advance the model, push the expectation.
   task automatic step(input logic ld, input logic [7:0] d, input logic a,
                       input logic c, input logic eod, input logic eoas,
                       input string tag);
      @(negedge clk);
      load = ld; load_data = d; a_gate = a; c_gate = c;
      dly_end = eod; a_sweep_end = eoas;
      @(posedge clk);
      if (ld) m_reg = d;
      if (eoas)     m_win = 1'b0;
      else if (eod) m_win = 1'b1;
      #1;
      sb_q.push_back('{exp: expect_vec(a, c), tag: tag});
      -> item_ev;
   endtask

   // Monitor: pop and compare each expectation as it arrives.
   initial begin
      forever begin
         @(item_ev);
         while (sb_q.size() > 0) begin
            cur = sb_q.pop_front();
            compare(cur.exp, cur.tag);
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();
      // delay-mode decoding
      step(1, mk(2'b00, 0, 2'b00, 2'b00, 0), 0, 0, 0, 0, "R3");
      step(1, mk(2'b01, 0, 2'b00, 2'b00, 0), 0, 0, 0, 0, "R4");
      step(1, mk(2'b10, 0, 2'b00, 2'b00, 0), 0, 0, 0, 0, "R5");
      step(1, mk(2'b11, 0, 2'b00, 2'b00, 0), 0, 0, 0, 0, "R5");
      // load low: everything holds
      step(0, mk(2'b00, 1, 2'b01, 2'b11, 1), 0, 0, 0, 0, "R2");
      step(1, mk(2'b10, 1, 2'b00, 2'b00, 1), 0, 0, 0, 0, "R11");
      step(1, mk(2'b10, 1, 2'b00, 2'b11, 1), 0, 0, 0, 0, "R10");
      // nongated
      step(0, 8'h00, 0, 0, 1, 0, "R6");
      step(0, 8'h00, 0, 0, 0, 1, "R6");
      // gate-following modes
      step(1, mk(2'b10, 0, 2'b10, 2'b00, 0), 0, 1, 0, 0, "R7");
      step(0, 8'h00, 1, 0, 0, 0, "R7");
      step(1, mk(2'b10, 0, 2'b11, 2'b00, 0), 1, 0, 0, 0, "R7");
      step(0, 8'h00, 0, 1, 0, 0, "R7");
      // window mode
      step(1, mk(2'b10, 0, 2'b01, 2'b00, 0), 1, 1, 0, 0, "R8");
      step(0, 8'h00, 0, 0, 1, 0, "R8");
      step(0, 8'h00, 0, 0, 0, 0, "R8");
      step(1, mk(2'b10, 0, 2'b01, 2'b10, 0), 0, 0, 0, 0, "R10");
      step(0, 8'h00, 0, 0, 0, 1, "R8");
      step(0, 8'h00, 1, 1, 0, 0, "R8");
      // simultaneous strobes
      step(0, 8'h00, 0, 0, 1, 0, "R9");
      step(0, 8'h00, 0, 0, 1, 1, "R9");
      step(0, 8'h00, 0, 0, 1, 1, "R9");
      // window follows strobes in another mode
      step(1, mk(2'b10, 0, 2'b00, 2'b00, 0), 0, 0, 1, 0, "R8");
      step(1, mk(2'b10, 0, 2'b01, 2'b00, 0), 0, 0, 0, 0, "R8");
      // reset clears the window
      do_reset();
      step(1, mk(2'b10, 0, 2'b01, 2'b00, 0), 0, 0, 0, 0, "R1");
      #20;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule